// File: doc/BRIEF.md
# Collision Backoff Countdown Generator

After a transmit collision, this block chooses a randomized retransmission delay and times it. It keeps a 16-bit load value that nearly doubles on each collision, so the average delay grows as the medium gets busier. The delay is built from an 8-bit slice of a free-running cycle counter masked by the low byte of the load. It is then counted down on an external periodic tick strobe, nominally one pulse every 37 us. When the count is used up, the block pulses an interface reset together with a transmitter start. If the load has already reached its top bit, the block reports a load-overflow failure and does not retry.

While the countdown runs, the receiver enable follows the "input buffer ready" input, so a packet that arrives during the wait can still be taken in. A post event during the countdown, such as a new command or a reset request, ends the wait with an abort pulse and no transmit. A clear input returns the load to zero when a new output command begins.

The controller has five states. IDLE waits for a collision. COUNT runs the countdown. LAUNCH lasts one cycle and starts the transmitter. OVERFLOW lasts one cycle and reports the failure. ABORT lasts one cycle and reports the abort. The transitions are as follows:
- IDLE→COUNT on a collision when the top load bit is clear.
- IDLE→OVERFLOW on a collision when the top load bit is set.
- COUNT→ABORT on a post event.
- COUNT→COUNT on a tick while the count is not zero, decrementing the count.
- COUNT→LAUNCH on a tick when the count is zero.
- LAUNCH, OVERFLOW and ABORT each return to IDLE on the next cycle.

Top module: `backoff_timer`

## Requirements
- R1: Reset places the block in IDLE with load 0, and tx_start_o, iface_reset_o, ovf_o, abort_o and rx_enable_o all low.
- R2: A collision accepted in IDLE when load bit 15 is 0 replaces the load with (old load << 1) + 1, visible on load_o on the next cycle.
- R3: A collision in IDLE when load bit 15 is 1 raises ovf_o for exactly one cycle, leaves the load unchanged and starts no countdown.
- R4: The countdown start value is bits [13:6] of a free-running cycle counter ANDed with bits [7:0] of the pre-update load. The counter is 0 at the first clock edge after reset release and increments on every edge. A start value N leads to a transmitter start after exactly N+1 ticks.
- R5: In COUNT, a tick with count 0 drives tx_start_o and iface_reset_o high together for exactly one cycle, starting on the next cycle. A tick with a nonzero count decrements the count.
- R6: Ticks outside COUNT have no effect, and collisions outside IDLE are ignored: load_o does not change and no pulse appears.
- R7: rx_enable_o is high exactly while in COUNT and rx_buf_ready_i is high.
- R8: abort_i in COUNT raises abort_o for one cycle on the next cycle and returns to IDLE with no transmitter start. abort_i takes priority over a tick in the same cycle and has no effect outside COUNT.
- R9: clear_load_i in IDLE sets the load to 0. A collision in the same cycle uses load 0, which gives a start value of 0 and a new load of 1. clear_load_i is ignored outside IDLE.
- R10: At most one of tx_start_o, ovf_o and abort_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_load_i | input | 1 | Return load to zero (new output command) |
| collision_i | input | 1 | Collision seen; request backoff |
| tick_i | input | 1 | Periodic countdown strobe |
| abort_i | input | 1 | Post event; abort the countdown |
| rx_buf_ready_i | input | 1 | Input buffer configured |
| tx_start_o | output | 1 | Transmitter start pulse |
| iface_reset_o | output | 1 | Interface reset pulse issued with the start |
| rx_enable_o | output | 1 | Receiver enable during countdown |
| ovf_o | output | 1 | Load-overflow failure pulse |
| abort_o | output | 1 | Abort status pulse |
| load_o | output | LOAD_W | Current load value |

## Verification
The bench pushes the load through sixteen collisions to 0xFFFF. A design that tested the top bit of the updated load instead of the old one would report overflow one collision early, and a design that updated the load on overflow would corrupt it. Zero start values, forced by a same-cycle clear and collision, check the N+1 tick rule: a design that launched on reaching zero instead of on a tick at zero would start one tick early. A tick and an abort in the same cycle, and abort pulses, ticks and collisions while idle, expose wrong priority or leaks from other states. Sparse ticks with a toggling buffer-ready input check that the receiver enable follows its input only during COUNT.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_COUNT  = 3'd1,
        ST_LAUNCH = 3'd2,
        ST_OVFL   = 3'd3,
        ST_ABORT  = 3'd4
    } bo_state_e;

endpackage

// File: rtl/bo_rand.sv
// Free-running cycle counter; exposes a fixed slice as the random byte.
module bo_rand #(
    parameter int RND_LSB = 6,
    parameter int RND_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [RND_W-1:0] rnd_o
);
    localparam int CW = RND_LSB + RND_W;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + {{(CW-1){1'b0}}, 1'b1};
        end
    end

    assign rnd_o = cnt_q[CW-1:RND_LSB];

endmodule

// File: rtl/bo_load.sv
// Growing load register: cleared on request, becomes (base<<1)+1 on grow.
module bo_load #(
    parameter int LOAD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              grow_i,
    output logic [LOAD_W-1:0] load_o
);
    logic [LOAD_W-1:0] load_q;
    logic [LOAD_W-1:0] base;

    always_comb begin
        base = clear_i ? '0 : load_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (grow_i) begin
            load_q <= {base[LOAD_W-2:0], 1'b1};
        end else if (clear_i) begin
            load_q <= '0;
        end
    end

    assign load_o = load_q;

endmodule

// File: rtl/bo_count.sv
// Countdown register with a load port and a decrement strobe.
module bo_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [CNT_W-1:0] set_val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (set_i) begin
            cnt_q <= set_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/backoff_timer.sv
module backoff_timer
    import backoff_pkg::*;
#(
    parameter int LOAD_W  = 16,
    parameter int RND_W   = 8,
    parameter int RND_LSB = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_load_i,
    input  logic              collision_i,
    input  logic              tick_i,
    input  logic              abort_i,
    input  logic              rx_buf_ready_i,
    output logic              tx_start_o,
    output logic              iface_reset_o,
    output logic              rx_enable_o,
    output logic              ovf_o,
    output logic              abort_o,
    output logic [LOAD_W-1:0] load_o
);
    localparam int MSB = LOAD_W - 1;

    bo_state_e        state_q;
    bo_state_e        state_d;
    logic [RND_W-1:0] rnd;
    logic [RND_W-1:0] seed;
    logic [LOAD_W-1:0] load;
    logic             in_idle;
    logic             clear_now;
    logic             top_bit;
    logic             col_ok;
    logic             col_bad;
    logic             cnt_zero;
    logic             dec_now;

    bo_rand #(.RND_LSB(RND_LSB), .RND_W(RND_W)) u_rand (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd)
    );

    bo_load #(.LOAD_W(LOAD_W)) u_load (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_now),
        .grow_i  (col_ok),
        .load_o  (load)
    );

    bo_count #(.CNT_W(RND_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (col_ok),
        .set_val_i (seed),
        .dec_i     (dec_now),
        .zero_o    (cnt_zero)
    );

    // Decode of collision outcome in IDLE (clear takes effect first).
    always_comb begin
        in_idle   = (state_q == ST_IDLE);
        clear_now = in_idle && clear_load_i;
        top_bit   = !clear_now && load[MSB];
        seed      = clear_now ? '0 : (rnd & load[RND_W-1:0]);
        col_ok    = in_idle && collision_i && !top_bit;
        col_bad   = in_idle && collision_i && top_bit;
        dec_now   = (state_q == ST_COUNT) && tick_i && !abort_i && !cnt_zero;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (col_bad) begin
                    state_d = ST_OVFL;
                end else if (col_ok) begin
                    state_d = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (abort_i) begin
                    state_d = ST_ABORT;
                end else if (tick_i && cnt_zero) begin
                    state_d = ST_LAUNCH;
                end
            end
            ST_LAUNCH: state_d = ST_IDLE;
            ST_OVFL:   state_d = ST_IDLE;
            ST_ABORT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        tx_start_o    = 1'b0;
        iface_reset_o = 1'b0;
        rx_enable_o   = 1'b0;
        ovf_o         = 1'b0;
        abort_o       = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_COUNT:  rx_enable_o = rx_buf_ready_i;
            ST_LAUNCH: begin
                tx_start_o    = 1'b1;
                iface_reset_o = 1'b1;
            end
            ST_OVFL:   ovf_o   = 1'b1;
            ST_ABORT:  abort_o = 1'b1;
            default:   ;
        endcase
    end

    assign load_o = load;

endmodule

// File: rtl/backoff_timer_chk.sv
module backoff_timer_chk
    import backoff_pkg::*;
#(
    parameter int LOAD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_load_i,
    input logic              collision_i,
    input logic              tick_i,
    input logic              abort_i,
    input logic              rx_buf_ready_i,
    input logic              tx_start_o,
    input logic              iface_reset_o,
    input logic              rx_enable_o,
    input logic              ovf_o,
    input logic              abort_o,
    input logic [LOAD_W-1:0] load_o,
    input bo_state_e         state_q
);
    a_r2_load_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && collision_i && !clear_load_i && !load_o[LOAD_W-1])
        |=> load_o == {$past(load_o[LOAD_W-2:0]), 1'b1});

    a_r3_load_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> load_o == $past(load_o));

    a_r5_one_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_o |=> !tx_start_o);

    a_r5_start_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_o |-> $past(state_q == ST_COUNT && tick_i && !abort_i));

    a_r5_reset_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_start_o) |-> iface_reset_o);

    a_r7_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        rx_enable_o |-> rx_buf_ready_i);

    a_r8_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(state_q == ST_COUNT && abort_i));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_start_o, ovf_o, abort_o}));

endmodule

bind backoff_timer backoff_timer_chk #(.LOAD_W(LOAD_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .clear_load_i   (clear_load_i),
    .collision_i    (collision_i),
    .tick_i         (tick_i),
    .abort_i        (abort_i),
    .rx_buf_ready_i (rx_buf_ready_i),
    .tx_start_o     (tx_start_o),
    .iface_reset_o  (iface_reset_o),
    .rx_enable_o    (rx_enable_o),
    .ovf_o          (ovf_o),
    .abort_o        (abort_o),
    .load_o         (load_o),
    .state_q        (state_q)
);

// File: tb/backoff_timer_test.sv
`timescale 1ns/100ps
module backoff_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_load_i = 1'b0;
    logic        collision_i = 1'b0;
    logic        tick_i = 1'b0;
    logic        abort_i = 1'b0;
    logic        rx_buf_ready_i = 1'b0;
    logic        tx_start_o, iface_reset_o, rx_enable_o, ovf_o, abort_o;
    logic [15:0] load_o;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // reference model: 0 idle, 1 count, 2 launch, 3 overflow, 4 abort
    int mstate = 0;
    int mload = 0;
    int mcount = 0;
    int mfree = 0;

    always #2.5 clk = ~clk;

    backoff_timer uut (
        .clk(clk), .rst_n(rst_n), .clear_load_i(clear_load_i),
        .collision_i(collision_i), .tick_i(tick_i), .abort_i(abort_i),
        .rx_buf_ready_i(rx_buf_ready_i), .tx_start_o(tx_start_o),
        .iface_reset_o(iface_reset_o), .rx_enable_o(rx_enable_o),
        .ovf_o(ovf_o), .abort_o(abort_o), .load_o(load_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R7 rx_enable", int'(rx_enable_o), int'(mstate == 1 && rx_buf_ready_i));
        chk("R5 tx_start", int'(tx_start_o), int'(mstate == 2));
        chk("R5 iface_reset", int'(iface_reset_o), int'(mstate == 2));
        chk("R3 ovf", int'(ovf_o), int'(mstate == 3));
        chk("R8 abort", int'(abort_o), int'(mstate == 4));
        chk("R2 load", int'(load_o), mload);
        chk("R10 exclusive", int'(tx_start_o) + int'(ovf_o) + int'(abort_o) <= 1, 1);
    endtask

    // one clock: compare, edge, model update, back to negedge
    task automatic cyc();
        int eff;
        #1;
        if (rst_n) compare_all();
        @(posedge clk);
        if (!rst_n) begin
            mstate = 0; mload = 0; mcount = 0; mfree = 0;
        end else begin
            case (mstate)
                0: begin
                    eff = clear_load_i ? 0 : mload;
                    if (clear_load_i) mload = 0;
                    if (collision_i) begin
                        if (eff >= 32768) mstate = 3;
                        else begin
                            mcount = ((mfree / 64) % 256) & (eff % 256);
                            mload = (eff * 2 + 1) % 65536;
                            mstate = 1;
                        end
                    end
                end
                1: begin
                    if (abort_i) mstate = 4;
                    else if (tick_i) begin
                        if (mcount == 0) mstate = 2;
                        else mcount--;
                    end
                end
                default: mstate = 0;
            endcase
            mfree = (mfree + 1) % 16384;
        end
        @(negedge clk);
    endtask

    // collision then ticks every gap cycles until start; R4 tick count check
    task automatic backoff(input int gap, input bit rx, input int idle_gap);
        int exp_ticks;
        int ticks;
        bit seen;
        repeat (idle_gap) cyc();
        exp_ticks = ((mfree / 64) % 256) & (mload % 256);
        exp_ticks = exp_ticks + 1;
        collision_i = 1; cyc(); collision_i = 0;
        ticks = 0;
        seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            tick_i = (i % gap) == 0;
            rx_buf_ready_i = rx ^ ((i % 7) == 3);
            #0.5;
            if (tx_start_o) seen = 1;
            else if (tick_i) ticks++;
            cyc();
        end
        tick_i = 0;
        rx_buf_ready_i = 0;
        chk("R4 ticks to start", ticks, exp_ticks);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        #1;
        chk("R1 load", int'(load_o), 0);
        chk("R1 pulses", int'({tx_start_o, iface_reset_o, rx_enable_o, ovf_o, abort_o}), 0);

        // R6/R8: ticks and aborts in idle do nothing
        for (int i = 0; i < 20; i++) begin
            tick_i = 1; abort_i = (i % 3) == 0; rx_buf_ready_i = 1;
            cyc();
        end
        tick_i = 0; abort_i = 0; rx_buf_ready_i = 0;
        chk("R6 idle ticks keep load", int'(load_o), 0);

        // R9: clear with collision -> start value 0, load 1
        clear_load_i = 1; collision_i = 1; cyc();
        clear_load_i = 0; collision_i = 0;
        chk("R9 load after clear+collision", int'(load_o), 1);
        tick_i = 1; cyc(); tick_i = 0;
        #1 chk("R9 zero start launches after one tick", int'(tx_start_o), 1);
        cyc();

        // normal backoffs, various patterns (R2, R4, R5, R7)
        backoff(1, 1, 300);
        backoff(3, 0, 1200);
        backoff(2, 1, 4000);

        // R8: abort mid countdown, tick in same cycle
        repeat (500) cyc();
        collision_i = 1; cyc(); collision_i = 0;
        tick_i = 1; abort_i = 1; cyc(); tick_i = 0; abort_i = 0;
        #1 chk("R8 abort wins over tick", int'(abort_o), 1);
        chk("R8 no start on abort", int'(tx_start_o), 0);
        cyc();

        // R6/R9: collision and clear during countdown ignored
        clear_load_i = 0;
        collision_i = 1; cyc(); collision_i = 0;
        begin
            int l0;
            l0 = mload;
            collision_i = 1; clear_load_i = 1; cyc(); cyc();
            collision_i = 0; clear_load_i = 0;
            chk("R6 collision in countdown ignored", int'(load_o), l0);
            chk("R9 clear in countdown ignored", int'(load_o), l0);
        end
        abort_i = 1; cyc(); abort_i = 0; cyc();

        // grow load to 0xFFFF then overflow (R2, R3)
        clear_load_i = 1; cyc(); clear_load_i = 0;
        for (int k = 0; k < 16; k++) backoff(1, k[0], 37 * k + 5);
        chk("R2 load saturated pattern", int'(load_o), 65535);
        collision_i = 1; cyc(); collision_i = 0;
        #1 chk("R3 overflow pulse", int'(ovf_o), 1);
        cyc();
        #1 chk("R3 overflow one cycle", int'(ovf_o), 0);
        chk("R3 load unchanged", int'(load_o), 65535);
        repeat (5) cyc();
        collision_i = 1; cyc(); collision_i = 0; cyc();
        clear_load_i = 1; cyc(); clear_load_i = 0;
        chk("R9 clear in idle", int'(load_o), 0);
        backoff(4, 1, 77);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule